// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This block resolves the fixed-point conditional trap instructions of a 64-bit RISC core whose instruction bits are numbered from the most significant end (bit 0 is the MSB). Each cycle that a valid instruction word is offered, the block works out whether it belongs to the trap family. There are four members: word or doubleword width, each with a register or an immediate second operand. For a family member, the block compares source A against source B, or against the sign-extended 16-bit immediate. It then masks the five comparison outcomes with the instruction's five-bit condition field.

One clock later, the registered outputs report the decision. A taken trap redirects fetch to the program-interrupt vector. It keeps the address of the trapping instruction itself as the fault address, and it hands back the incoming status word with the trap-cause bit set. An untaken trap simply continues at the next sequential address. A word that is not in the family is flagged as unhandled and also continues sequentially. The block writes no registers and no condition fields: the register file and the interrupt controller sit outside it.

Top module: `trap_eval_unit`

## Requirements
- R1: Decoding uses instruction bits [31:26] as the primary opcode and [10:1] as the extended opcode. The family members are: opcode 31 with extended 4 (word, register), opcode 31 with extended 68 (doubleword, register), opcode 3 (word, immediate) and opcode 2 (doubleword, immediate). Any other word raises `unhandled`, never traps, and sets `next_pc` to `cia`+4.
- R2: The condition mask is instruction bits [25:21]. Mask value 16 tests signed A<B, 8 tests signed A>B, 4 tests A==B, 2 tests unsigned A<B and 1 tests unsigned A>B. The trap fires when any enabled test holds.
- R3: The word forms compare only bits [31:0] of each operand, and the upper bits have no effect. The doubleword forms compare all 64 bits.
- R4: The immediate forms use instruction bits [15:0] as B, sign-extended to the comparison width, and ignore `op_b`.
- R5: A mask of 31 always traps. In particular, 0x7FE00008 traps for any operand values.
- R6: A mask of 0 never traps. In particular, 0x7C000008 falls through to `cia`+4.
- R7: An untaken evaluation gives `next_pc` = `cia`+4, `fault_addr` = 0 and `saved_status` = `status_in` unchanged.
- R8: A taken trap gives `next_pc` = 0x700, `fault_addr` = `cia` of the trapping instruction, and `saved_status` = `status_in` with bit 17 set.
- R9: Instruction bit 0 (the record flag) has no effect on any output.
- R10: All results appear one clock after `in_valid` is sampled high, together with `out_valid`. In a cycle after `in_valid` was low, `out_valid`, `trap_taken` and `unhandled` are 0. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the instruction and operands this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 64 | Source A register value |
| op_b | input | 64 | Source B register value (unused by immediate forms) |
| cia | input | 64 | Address of the instruction being evaluated |
| status_in | input | 64 | Current machine status word to be saved |
| out_valid | output | 1 | Result registers hold a fresh evaluation |
| trap_taken | output | 1 | Trap condition held; redirect to the vector |
| unhandled | output | 1 | Instruction is not a trap-family member |
| fault_addr | output | 64 | Address of the trapping instruction, else 0 |
| saved_status | output | 64 | Status word to save, with the cause bit set on a trap |
| next_pc | output | 64 | Next fetch address |

## Verification
The assertions assume the following about the inputs: reset is held for at least one rising edge before the first valid request, and `cia` and `instr` stay steady between the driving edge and the sampling edge, so that `$past` of an input names the request that produced the result. The stimulus drives every input on the falling edge and keeps it for the whole cycle. It also lets `cia`+4 wrap freely, because the sequential-address check uses modular arithmetic. Random instruction words are built from the four family encodings plus foreign opcodes. The operand values are biased toward equal low halves and differing upper halves, so that the equality and word-width cases occur often.

// File: rtl/trap_pkg.sv
package trap_pkg;

   // Primary and extended opcode values of the trap family
   localparam logic [5:0] OPC_XFORM = 6'd31;
   localparam logic [5:0] OPC_TWI   = 6'd3;
   localparam logic [5:0] OPC_TDI   = 6'd2;
   localparam logic [9:0] XO_TW     = 10'd4;
   localparam logic [9:0] XO_TD     = 10'd68;

   // Bit positions inside the five-bit condition mask (LSB-numbered)
   localparam int unsigned CND_SLT = 4;
   localparam int unsigned CND_SGT = 3;
   localparam int unsigned CND_EQ  = 2;
   localparam int unsigned CND_ULT = 1;
   localparam int unsigned CND_UGT = 0;
   localparam int unsigned CND_W   = 5;

   typedef enum logic [2:0] {
      FORM_NONE = 3'd0,
      FORM_WREG = 3'd1,
      FORM_DREG = 3'd2,
      FORM_WIMM = 3'd3,
      FORM_DIMM = 3'd4
   } trap_form_e;

   typedef struct packed {
      trap_form_e        form;
      logic [CND_W-1:0]  cmask;
      logic [15:0]       imm;
      logic              is_word;
      logic              is_imm;
   } trap_dec_t;

endpackage

// File: rtl/trap_decode.sv
module trap_decode
   import trap_pkg::*;
#(
   parameter int unsigned ILEN = 32
) (
   input  logic [ILEN-1:0] instr,
   output trap_dec_t       dec
);

   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("trap_decode: ILEN must be 32");
      end
   endgenerate

   // MSB-numbered bit k is instr[ILEN-1-k]
   localparam int unsigned PO_HI = ILEN - 1;
   localparam int unsigned PO_LO = ILEN - 6;
   localparam int unsigned MK_HI = ILEN - 7;
   localparam int unsigned MK_LO = ILEN - 11;
   localparam int unsigned XO_HI = ILEN - 22;
   localparam int unsigned XO_LO = ILEN - 31;

   logic [5:0] prim;
   logic [9:0] ext;
   logic [5:0] unused_fields;

   assign prim          = instr[PO_HI:PO_LO];
   assign ext           = instr[XO_HI:XO_LO];
   assign unused_fields = {instr[20:16], instr[0]};

   always_comb begin
      dec.cmask = instr[MK_HI:MK_LO];
      dec.imm   = instr[15:0];
      dec.form  = FORM_NONE;
      if (prim == OPC_XFORM && ext == XO_TW)      dec.form = FORM_WREG;
      else if (prim == OPC_XFORM && ext == XO_TD) dec.form = FORM_DREG;
      else if (prim == OPC_TWI)                   dec.form = FORM_WIMM;
      else if (prim == OPC_TDI)                   dec.form = FORM_DIMM;
      dec.is_word = (dec.form == FORM_WREG) || (dec.form == FORM_WIMM);
      dec.is_imm  = (dec.form == FORM_WIMM) || (dec.form == FORM_DIMM);
   end

endmodule

// File: rtl/trap_compare.sv
module trap_compare
   import trap_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   output logic [CND_W-1:0] hits
);

   generate
      if (W < 2) begin : g_bad_w
         $error("trap_compare: W must be at least 2");
      end
   endgenerate

   logic s_lt, u_lt, eq;

   assign eq   = (a == b);
   assign u_lt = (a < b);
   assign s_lt = ($signed(a) < $signed(b));

   always_comb begin
      hits          = '0;
      hits[CND_SLT] = s_lt;
      hits[CND_SGT] = !s_lt && !eq;
      hits[CND_EQ]  = eq;
      hits[CND_ULT] = u_lt;
      hits[CND_UGT] = !u_lt && !eq;
   end

   // R2: exactly one signed relation and one unsigned relation hold
   always_comb begin
      signed_rel_chk: assert ($onehot({hits[CND_SLT], hits[CND_SGT], hits[CND_EQ]}));
      unsigned_rel_chk: assert ($onehot({hits[CND_ULT], hits[CND_UGT], hits[CND_EQ]}));
   end

endmodule

// File: rtl/trap_redirect.sv
module trap_redirect #(
   parameter int unsigned       XLEN     = 64,
   parameter logic [XLEN-1:0]   VECTOR   = 64'h700,
   parameter int unsigned       STEP     = 4,
   parameter int unsigned       TRAP_BIT = 17
) (
   input  logic            fire,
   input  logic [XLEN-1:0] cia,
   input  logic [XLEN-1:0] status_in,
   output logic [XLEN-1:0] nxt_pc,
   output logic [XLEN-1:0] nxt_fault,
   output logic [XLEN-1:0] nxt_status
);

   generate
      if (TRAP_BIT >= XLEN) begin : g_bad_bit
         $error("trap_redirect: TRAP_BIT outside status word");
      end
   endgenerate

   localparam logic [XLEN-1:0] CAUSE = {{(XLEN-1){1'b0}}, 1'b1} << TRAP_BIT;
   localparam logic [XLEN-1:0] INC   = XLEN'(STEP);

   always_comb begin
      if (fire) begin
         nxt_pc     = VECTOR;
         nxt_fault  = cia;
         nxt_status = status_in | CAUSE;
      end else begin
         nxt_pc     = cia + INC;
         nxt_fault  = '0;
         nxt_status = status_in;
      end
   end

endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
   import trap_pkg::*;
#(
   parameter int unsigned       XLEN     = 64,
   parameter int unsigned       ILEN     = 32,
   parameter int unsigned       WORD_W   = 32,
   parameter logic [XLEN-1:0]   VECTOR   = 64'h700,
   parameter int unsigned       STEP     = 4,
   parameter int unsigned       TRAP_BIT = 17
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [ILEN-1:0] instr,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [XLEN-1:0] cia,
   input  logic [XLEN-1:0] status_in,
   output logic            out_valid,
   output logic            trap_taken,
   output logic            unhandled,
   output logic [XLEN-1:0] fault_addr,
   output logic [XLEN-1:0] saved_status,
   output logic [XLEN-1:0] next_pc
);

   localparam int unsigned IMM_W = 16;

   generate
      if (XLEN < WORD_W || WORD_W < IMM_W) begin : g_bad_widths
         $error("trap_eval_unit: need XLEN >= WORD_W >= 16");
      end
   endgenerate

   trap_dec_t dec;

   trap_decode #(.ILEN(ILEN)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   // Second operand: register or sign-extended immediate
   logic [XLEN-1:0] b_sel;
   assign b_sel = dec.is_imm ? {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm} : op_b;

   logic [CND_W-1:0] hits_word, hits_full, hits;

   trap_compare #(.W(WORD_W)) u_cmp_word (
      .a    (op_a[WORD_W-1:0]),
      .b    (b_sel[WORD_W-1:0]),
      .hits (hits_word)
   );

   generate
      if (XLEN > WORD_W) begin : g_wide
         trap_compare #(.W(XLEN)) u_cmp_full (
            .a    (op_a),
            .b    (b_sel),
            .hits (hits_full)
         );
      end else begin : g_narrow
         assign hits_full = hits_word;
      end
   endgenerate

   assign hits = dec.is_word ? hits_word : hits_full;

   logic is_family, fire;
   assign is_family = (dec.form != FORM_NONE);
   assign fire      = is_family && |(hits & dec.cmask);

   logic [XLEN-1:0] nxt_pc, nxt_fault, nxt_status;

   trap_redirect #(
      .XLEN(XLEN), .VECTOR(VECTOR), .STEP(STEP), .TRAP_BIT(TRAP_BIT)
   ) u_redir (
      .fire       (fire),
      .cia        (cia),
      .status_in  (status_in),
      .nxt_pc     (nxt_pc),
      .nxt_fault  (nxt_fault),
      .nxt_status (nxt_status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         trap_taken   <= 1'b0;
         unhandled    <= 1'b0;
         fault_addr   <= '0;
         saved_status <= '0;
         next_pc      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            trap_taken   <= fire;
            unhandled    <= !is_family;
            fault_addr   <= nxt_fault;
            saved_status <= nxt_status;
            next_pc      <= nxt_pc;
         end else begin
            trap_taken   <= 1'b0;
            unhandled    <= 1'b0;
         end
      end
   end

   // ---------------- assertions ----------------
   // R10
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!trap_taken && !unhandled));

   // R1
   excl_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_taken, unhandled}));

   // R8
   vector_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && trap_taken) |-> (next_pc == VECTOR && saved_status[TRAP_BIT]));

   // R8
   fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!trap_taken || fault_addr == $past(cia)));

   // R7
   seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (trap_taken || next_pc == $past(cia) + XLEN'(STEP)));

   // R6
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec.cmask == '0) |=> !trap_taken);

   // R5
   full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_family && dec.cmask == '1) |=> trap_taken);

endmodule

// File: tb/trap_eval_unit_tb.sv
module trap_eval_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] op_a = '0, op_b = '0, cia = '0, status_in = '0;
   logic            out_valid, trap_taken, unhandled;
   logic [XLEN-1:0] fault_addr, saved_status, next_pc;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_eval_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .op_a(op_a), .op_b(op_b), .cia(cia), .status_in(status_in),
      .out_valid(out_valid), .trap_taken(trap_taken), .unhandled(unhandled),
      .fault_addr(fault_addr), .saved_status(saved_status), .next_pc(next_pc)
   );

   function automatic logic [31:0] enc_x(int po, int mk, int xo, bit rc);
      return {6'(po), 5'(mk), 5'd3, 5'd4, 10'(xo), rc};
   endfunction

   function automatic logic [31:0] enc_i(int po, int mk, logic [15:0] imm);
      return {6'(po), 5'(mk), 5'd3, imm};
   endfunction

   // expected results of the current request
   logic            e_valid, e_trap, e_unh;
   logic [XLEN-1:0] e_fault, e_stat, e_pc;

   task automatic model(input logic v, input logic [31:0] iw, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] pc, input logic [63:0] st);
      int po, xo, mk, kind;
      longint sa, sb;
      longint unsigned ua, ub, bv;
      bit fire;
      po = int'(iw >> 26);
      xo = int'((iw >> 1) & 32'h3FF);
      mk = int'((iw >> 21) & 32'h1F);
      kind = 0;
      if (po == 31 && xo == 4) kind = 1;
      else if (po == 31 && xo == 68) kind = 2;
      else if (po == 3) kind = 3;
      else if (po == 2) kind = 4;
      if (kind >= 3) bv = longint'($signed(iw[15:0])); else bv = b;
      if (kind == 1 || kind == 3) begin
         sa = longint'($signed(a[31:0])); sb = longint'($signed(bv[31:0]));
         ua = {32'd0, a[31:0]};           ub = {32'd0, bv[31:0]};
      end else begin
         sa = $signed(a); sb = $signed(bv); ua = a; ub = bv;
      end
      fire = 0;
      if (kind != 0) begin
         if ((mk & 16) != 0 && sa < sb) fire = 1;
         if ((mk & 8)  != 0 && sa > sb) fire = 1;
         if ((mk & 4)  != 0 && ua == ub) fire = 1;
         if ((mk & 2)  != 0 && ua < ub) fire = 1;
         if ((mk & 1)  != 0 && ua > ub) fire = 1;
      end
      e_valid = v;
      if (v) begin
         e_trap  = fire;
         e_unh   = (kind == 0);
         e_fault = fire ? pc : 64'd0;
         e_stat  = fire ? (st | (64'd1 << 17)) : st;
         e_pc    = fire ? 64'h700 : pc + 64'd4;
      end else begin
         e_trap = 0; e_unh = 0;
      end
   endtask

   task automatic check(input string tag);
      checks++;
      if (out_valid !== e_valid || trap_taken !== e_trap || unhandled !== e_unh ||
          (e_valid && (fault_addr !== e_fault || saved_status !== e_stat || next_pc !== e_pc))) begin
         failures++;
         $display("FAIL %s: got v=%0b t=%0b u=%0b fa=%h st=%h pc=%h exp v=%0b t=%0b u=%0b fa=%h st=%h pc=%h",
                  tag, out_valid, trap_taken, unhandled, fault_addr, saved_status, next_pc,
                  e_valid, e_trap, e_unh, e_fault, e_stat, e_pc);
      end
   endtask

   // one request per clock: drive after falling edge, compare at the next falling edge
   task automatic apply(input logic v, input logic [31:0] iw, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] pc, input logic [63:0] st,
                        input string tag);
      in_valid = v; instr = iw; op_a = a; op_b = b; cia = pc; status_in = st;
      model(v, iw, a, b, pc, st);
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic expect_trap(input bit want, input string tag);
      checks++;
      if (trap_taken !== want) begin
         failures++;
         $display("FAIL %s: trap_taken got %0b exp %0b", tag, trap_taken, want);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] hi_a;
      repeat (3) @(negedge clk);
      // R10: reset state
      checks++;
      if (out_valid !== 0 || trap_taken !== 0 || unhandled !== 0 ||
          next_pc !== 0 || fault_addr !== 0 || saved_status !== 0) begin
         failures++;
         $display("FAIL R10 reset: got v=%0b t=%0b pc=%h exp all zero", out_valid, trap_taken, next_pc);
      end
      rst_n = 1'b1;

      // R5: unconditional idiom
      apply(1, 32'h7FE00008, 64'd5, 64'd9, 64'h1000, 64'h8000, "R5 idiom");
      expect_trap(1, "R5 idiom");
      // R6: inert idiom
      apply(1, 32'h7C000008, 64'd5, 64'd5, 64'h1004, 64'h8000, "R6 inert");
      expect_trap(0, "R6 inert");
      // R2: signed less than with negative A
      apply(1, enc_x(31, 16, 4, 0), 64'hFFFF_FFFF, 64'd1, 64'h2000, 64'h0, "R2 slt");
      expect_trap(1, "R2 slt");
      apply(1, enc_x(31, 2, 4, 0), 64'hFFFF_FFFF, 64'd1, 64'h2004, 64'h0, "R2 ult");
      expect_trap(0, "R2 ult");
      apply(1, enc_x(31, 1, 4, 0), 64'hFFFF_FFFF, 64'd1, 64'h2008, 64'h0, "R2 ugt");
      expect_trap(1, "R2 ugt");
      // R3: upper halves differ, low halves equal
      hi_a = 64'hABCD_0000_0000_0042;
      apply(1, enc_x(31, 4, 4, 0), hi_a, 64'h42, 64'h3000, 64'h1, "R3 word eq");
      expect_trap(1, "R3 word eq");
      apply(1, enc_x(31, 4, 68, 0), hi_a, 64'h42, 64'h3004, 64'h1, "R3 dword ne");
      expect_trap(0, "R3 dword ne");
      // R4: immediate -1 sign-extended, op_b ignored
      apply(1, enc_i(3, 8, 16'hFFFF), 64'd0, 64'd100, 64'h4000, 64'h0, "R4 wimm sgt");
      expect_trap(1, "R4 wimm sgt");
      apply(1, enc_i(2, 2, 16'hFFFF), 64'd5, 64'd0, 64'h4004, 64'h0, "R4 dimm ult");
      expect_trap(1, "R4 dimm ult");
      // R9: record flag set gives the same result
      apply(1, enc_x(31, 4, 4, 1), 64'd7, 64'd7, 64'h5000, 64'h0, "R9 rc");
      expect_trap(1, "R9 rc");
      // R1: foreign opcode and foreign extended opcode
      apply(1, enc_i(14, 31, 16'h0), 64'd0, 64'd0, 64'h6000, 64'h0, "R1 foreign");
      apply(1, enc_x(31, 31, 5, 0), 64'd0, 64'd0, 64'h6004, 64'h0, "R1 xo");
      // R10: idle cycle
      apply(0, enc_x(31, 31, 4, 0), 64'd0, 64'd0, 64'h7000, 64'h0, "R10 idle");
      // R8/R7: wrap of sequential address and status propagation
      apply(1, enc_x(31, 0, 68, 0), 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'h5A5A, "R7 wrap");
      apply(1, enc_x(31, 24, 68, 0), 64'd1, 64'd2, 64'h8000, 64'h5A5A, "R8 ne");

      // random mix compared every clock
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] iw;
         logic [63:0] ra, rb;
         int sel;
         sel = int'($urandom_range(0, 5));
         case (sel)
            0: iw = enc_x(31, int'($urandom_range(0, 31)), 4, 1'($urandom));
            1: iw = enc_x(31, int'($urandom_range(0, 31)), 68, 1'($urandom));
            2: iw = enc_i(3, int'($urandom_range(0, 31)), 16'($urandom));
            3: iw = enc_i(2, int'($urandom_range(0, 31)), 16'($urandom));
            default: iw = $urandom;
         endcase
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) rb = {$urandom, ra[31:0]};
         if ($urandom_range(0, 5) == 0) rb = ra;
         apply(1'($urandom_range(0, 7) != 0), iw, ra, rb, {$urandom, $urandom}, {$urandom, $urandom},
               "R2 R3 R4 R7 R8 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule